// File: doc/BRIEF.md
# Burst Wrap Address Sequencer

This block produces the byte address sequence for a serial-flash read. A read can run linearly, or it can cycle inside a small aligned window of a 256-byte page. A separate configuration strobe stores a three-bit wrap setting. One bit of that setting turns wrapping on or off. The other two bits choose a window of 8, 16, 32 or 64 bytes. The setting remains in force for every later read until it is rewritten.

While chip select is low, a start strobe loads the 24-bit start address of a read. Each data byte strobe after that advances the address by one byte. In wrap mode the window's upper address bits stay fixed. After the window's last byte, the address returns to the window's first byte. The read carries on this way until chip select goes high. In linear mode the address counts through the whole 24-bit space. A read that ends is replaced by the next start. Pin-level shifting and the memory array are outside this block.

Top module: `burst_wrap_seq`

## Requirements
- R1: After reset, cur_addr is 0x000000 and the stored wrap setting is 3'b111, so wrapping is off. A read started before any configuration write therefore counts linearly, for example 0x0000FE, 0x0000FF, 0x000100.
- R2: When start_valid is high and cs_n is low at a clock edge, cur_addr equals start_addr after that edge.
- R3: When the read's setting has cfg_wrap[0] = 1 (linear), each accepted byte_advance adds one to cur_addr modulo 2^24. The count crosses page boundaries and rolls over from 0xFFFFFF to 0x000000.
- R4: When the read's setting has cfg_wrap[0] = 0 (wrap), cfg_wrap[2:1] selects the window length: 00 gives 8 bytes, 01 gives 16, 10 gives 32 and 11 gives 64. An advance keeps every address bit above the window fixed. After the window's last byte, the address becomes the window's first byte.
- R5: A read that starts inside a window delivers the start address first. It then runs to the window's end, wraps to the window's lower boundary, and keeps cycling.
- R6: A write with cfg_we high stores cfg_wrap after that edge. A read uses the setting that is stored when it starts. A write made during a read, or in the same cycle as its start, takes effect only from the next start.
- R7: While cs_n is high, start_valid and byte_advance are ignored and cur_addr holds. Raising cs_n ends the read. After cs_n falls again, byte_advance has no effect until a new start_valid arrives.
- R8: When start_valid and byte_advance are both high in the same cycle, the load wins and cur_addr equals start_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; high ends a read |
| start_valid | input | 1 | Load start_addr and begin a read |
| start_addr | input | 24 | Start byte address of the read |
| byte_advance | input | 1 | One pulse per data byte transferred |
| cfg_we | input | 1 | Write strobe for the wrap setting |
| cfg_wrap | input | 3 | Bit 0 = 0 selects wrap and 1 selects linear; bits 2:1 select the window length |
| cur_addr | output | 24 | Address of the current data byte |

## Verification
Every result is registered once, so a load, an advance or a configuration write shows on the outputs one clock edge after the edge that samples it. The bench drives inputs on the falling edge and lets one rising edge pass. It compares cur_addr on the next falling edge against its own model, which applies the same rule. A configuration write is seen only at the following start, and the directed checks sample it there. Mid-read writes and same-cycle writes are checked on the advances that follow them.

// File: rtl/burst_wrap_pkg.sv
package burst_wrap_pkg;
  localparam int ADDR_W       = 24;
  localparam int NUM_LEN      = 4;
  localparam int MIN_LEN_LOG2 = 3;
  localparam int SEL_W        = $clog2(NUM_LEN);
  localparam int CFG_W        = SEL_W + 1;
  localparam int MAX_LEN_LOG2 = MIN_LEN_LOG2 + NUM_LEN - 1;
  localparam logic [CFG_W-1:0] CFG_RST = '1;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CFG_W-1:0]  cfg_t;

  // Low-bit mask of the window selected by sel (window length minus one).
  function automatic addr_t wrap_mask(input logic [SEL_W-1:0] sel);
    addr_t m;
    m = '0;
    for (int i = 0; i < MAX_LEN_LOG2; i++) begin
      if (i < MIN_LEN_LOG2 + int'(sel)) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Setting bit 0 low means wrapping is on.
  function automatic logic wrap_on(input cfg_t c);
    return ~c[0];
  endfunction

  function automatic logic [SEL_W-1:0] len_sel(input cfg_t c);
    return c[CFG_W-1:1];
  endfunction
endpackage

// File: rtl/wrap_cfg_reg.sv
module wrap_cfg_reg
  import burst_wrap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  cfg_t cfg_wrap,
  output cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (cfg_we) cfg_q <= cfg_wrap;
  end
endmodule

// File: rtl/wrap_next_addr.sv
module wrap_next_addr
  import burst_wrap_pkg::*;
(
  input  addr_t addr,
  input  cfg_t  mode,
  output addr_t next_addr,
  output logic  at_win_end
);
  addr_t cand [NUM_LEN];
  logic  endv [NUM_LEN];
  addr_t lin_next;

  assign lin_next = addr + ADDR_W'(1);

  // One candidate per window length; the carry out of the window is dropped.
  for (genvar g = 0; g < NUM_LEN; g++) begin : g_len
    localparam int LG = MIN_LEN_LOG2 + g;
    logic [LG-1:0] low_inc;
    assign low_inc = addr[LG-1:0] + LG'(1);
    assign cand[g] = {addr[ADDR_W-1:LG], low_inc};
    assign endv[g] = &addr[LG-1:0];
  end

  always_comb begin
    if (wrap_on(mode)) begin
      next_addr  = cand[len_sel(mode)];
      at_win_end = endv[len_sel(mode)];
    end else begin
      next_addr  = lin_next;
      at_win_end = 1'b0;
    end
  end
endmodule

// File: rtl/wrap_addr_ctrl.sv
module wrap_addr_ctrl
  import burst_wrap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_n,
  input  logic  start_valid,
  input  addr_t start_addr,
  input  logic  byte_advance,
  input  cfg_t  cfg_q,
  input  addr_t next_addr,
  output addr_t cur_addr,
  output cfg_t  mode_q,
  output logic  rd_active,
  output logic  load_evt,
  output logic  step_evt
);
  assign load_evt = ~cs_n & start_valid;
  assign step_evt = ~cs_n & ~start_valid & byte_advance & rd_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      mode_q    <= CFG_RST;
      rd_active <= 1'b0;
    end else if (cs_n) begin
      rd_active <= 1'b0;
    end else if (load_evt) begin
      cur_addr  <= start_addr;
      mode_q    <= cfg_q;
      rd_active <= 1'b1;
    end else if (step_evt) begin
      cur_addr  <= next_addr;
    end
  end
endmodule

// File: rtl/burst_wrap_seq.sv
module burst_wrap_seq
  import burst_wrap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              start_valid,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_advance,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wrap,
  output logic [ADDR_W-1:0] cur_addr
);
  cfg_t  cfg_q;
  cfg_t  mode_q;
  addr_t next_addr;
  logic  at_win_end;
  logic  rd_active;
  logic  load_evt;
  logic  step_evt;
  logic  wrap_evt;

  wrap_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wrap(cfg_wrap), .cfg_q(cfg_q)
  );

  wrap_next_addr u_next (
    .addr(cur_addr), .mode(mode_q), .next_addr(next_addr), .at_win_end(at_win_end)
  );

  wrap_addr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start_valid(start_valid),
    .start_addr(start_addr), .byte_advance(byte_advance), .cfg_q(cfg_q),
    .next_addr(next_addr), .cur_addr(cur_addr), .mode_q(mode_q),
    .rd_active(rd_active), .load_evt(load_evt), .step_evt(step_evt)
  );

  // Named event for the checker: an advance taken from a window's last byte.
  assign wrap_evt = step_evt & at_win_end;
endmodule

// File: rtl/burst_wrap_seq_chk.sv
module burst_wrap_seq_chk
  import burst_wrap_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  cs_n,
  input logic  start_valid,
  input addr_t start_addr,
  input logic  cfg_we,
  input cfg_t  cfg_wrap,
  input addr_t cur_addr,
  input cfg_t  cfg_q,
  input cfg_t  mode_q,
  input logic  rd_active,
  input logic  step_evt,
  input logic  wrap_evt
);
  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && start_valid) |=> cur_addr == $past(start_addr));

  // R3
  lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && mode_q[0]) |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

  // R4
  win_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !mode_q[0]) |=>
      ((cur_addr ^ $past(cur_addr)) & ~wrap_mask($past(mode_q[CFG_W-1:1]))) == '0);

  // R5
  wrap_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cur_addr & wrap_mask($past(mode_q[CFG_W-1:1]))) == '0);

  // R6
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == $past(cfg_wrap));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_valid && !cs_n) |=> $stable(mode_q));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(cur_addr) && !rd_active);
endmodule

bind burst_wrap_seq burst_wrap_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start_valid(start_valid),
  .start_addr(start_addr), .cfg_we(cfg_we), .cfg_wrap(cfg_wrap),
  .cur_addr(cur_addr), .cfg_q(cfg_q), .mode_q(mode_q), .rd_active(rd_active),
  .step_evt(step_evt), .wrap_evt(wrap_evt)
);

// File: tb/burst_wrap_seq_tb.sv
`timescale 1ns/1ps
module burst_wrap_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        start_valid = 1'b0;
  logic [23:0] start_addr = '0;
  logic        byte_advance = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_wrap = '0;
  logic [23:0] cur_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [23:0] m_addr = '0;
  logic [2:0]  m_cfg = 3'b111;
  logic [2:0]  m_mode = 3'b111;
  bit          m_act = 0;

  always #5 clk = ~clk;

  burst_wrap_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start_valid(start_valid),
    .start_addr(start_addr), .byte_advance(byte_advance), .cfg_we(cfg_we),
    .cfg_wrap(cfg_wrap), .cur_addr(cur_addr)
  );

  // Bench model of one advance: base-plus-offset modulo the window length.
  function automatic logic [23:0] m_next(input logic [23:0] a, input logic [2:0] md);
    int unsigned len, base, off;
    if (md[0]) return a + 24'd1;
    len  = 32'd8 << md[2:1];
    base = int'(a) - (int'(a) % len);
    off  = (int'(a) - base + 1) % len;
    return 24'(base + off);
  endfunction

  task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: cur_addr=%06h expected=%06h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic cs, input logic sv, input logic [23:0] sa,
                     input logic adv, input logic we, input logic [2:0] cw);
    cs_n = cs; start_valid = sv; start_addr = sa;
    byte_advance = adv; cfg_we = we; cfg_wrap = cw;
    @(posedge clk);
    if (cs) m_act = 0;
    else if (sv) begin m_addr = sa; m_mode = m_cfg; m_act = 1; end
    else if (adv && m_act) m_addr = m_next(m_addr, m_mode);
    if (we) m_cfg = cw;
    @(negedge clk);
  endtask

  task automatic adv_n(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 24'h0, 1, 0, 3'b000);
  endtask

  task automatic set_cfg(input logic [2:0] cw);
    cyc(1, 0, 24'h0, 0, 1, cw);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: cur_addr=%06h expected=done", cur_addr);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset address", cur_addr, 24'h000000);

    // R1: default setting counts linearly past window and page edges
    cyc(0, 1, 24'h0000FE, 0, 0, 3'b000);
    check("R2 load", cur_addr, 24'h0000FE);
    adv_n(1); check("R1 linear default", cur_addr, 24'h0000FF);
    adv_n(1); check("R1 linear default page cross", cur_addr, 24'h000100);

    // R3: rollover at top of space
    cyc(1, 0, 24'h0, 0, 0, 3'b000);
    cyc(0, 1, 24'hFFFFFE, 0, 0, 3'b000);
    adv_n(2); check("R3 rollover", cur_addr, 24'h000000);

    // R4: each window length wraps to 0x1234C0
    for (int s = 0; s < 4; s++) begin
      int unsigned len;
      len = 32'd8 << s;
      set_cfg({2'(s), 1'b0});
      cyc(0, 1, 24'h1234C0 + 24'(len - 2), 0, 0, 3'b000);
      adv_n(1); check("R4 window last byte", cur_addr, 24'h1234C0 + 24'(len - 1));
      adv_n(1); check("R4 window wrap", cur_addr, 24'h1234C0);
      cyc(1, 0, 24'h0, 0, 0, 3'b000);
    end

    // R5: mid-window start with a 16-byte window
    set_cfg(3'b010);
    cyc(0, 1, 24'h00A0B7, 0, 0, 3'b000);
    check("R5 first byte", cur_addr, 24'h00A0B7);
    adv_n(9); check("R5 wrap to boundary", cur_addr, 24'h00A0B0);
    adv_n(7); check("R5 cycle back", cur_addr, 24'h00A0B7);

    // R6: mid-read write does not apply; next read uses it
    cyc(1, 0, 24'h0, 0, 0, 3'b000);
    set_cfg(3'b000);
    cyc(0, 1, 24'h000206, 0, 0, 3'b000);
    cyc(0, 0, 24'h0, 1, 1, 3'b111);
    adv_n(1); check("R6 mid-read write ignored", cur_addr, 24'h000200);
    cyc(1, 0, 24'h0, 0, 0, 3'b000);
    cyc(0, 1, 24'h000206, 0, 0, 3'b000);
    adv_n(2); check("R6 new setting at next start", cur_addr, 24'h000208);
    // R6: same-cycle write with start uses the old (linear) setting
    cyc(1, 0, 24'h0, 0, 0, 3'b000);
    cyc(0, 1, 24'h000307, 0, 1, 3'b000);
    adv_n(1); check("R6 same-cycle write uses old", cur_addr, 24'h000308);

    // R7: cs_n high ignores strobes; advance without start after reselect ignored
    cyc(1, 1, 24'h777777, 1, 0, 3'b000);
    check("R7 hold while deselected", cur_addr, 24'h000308);
    cyc(0, 0, 24'h0, 1, 0, 3'b000);
    check("R7 no advance before start", cur_addr, 24'h000308);

    // R8: load wins over advance
    cyc(0, 1, 24'h4455AA, 1, 0, 3'b000);
    check("R8 load priority", cur_addr, 24'h4455AA);

    // Random phase against the model
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic cs, sv, adv, we;
      logic [23:0] sa;
      cs  = ($urandom % 16) == 0;
      sv  = ($urandom % 10) == 0;
      adv = ($urandom % 10) < 7;
      we  = ($urandom % 20) == 0;
      sa  = (($urandom % 4) == 0) ? (24'hFFFFC0 | 24'($urandom % 64)) : 24'($urandom);
      cyc(cs, sv, sa, adv, we, 3'($urandom));
      check("R2/R4 random", cur_addr, m_addr);
    end

    finish_run();
  end
endmodule